// File: doc/BRIEF.md
# Auxiliary Notification Doorbell Decoder

This block sits behind the address decode of one memory window. A driver rings a doorbell by writing to an address inside that window. The block turns each such write into a one-cycle pulse on one of `N_NOTIFY` notification lines. Three configuration inputs describe the layout: a base offset, a per-index stride called the multiplier, and the window length. Index `k` owns the address `base + k * multiplier`. A multiplier of zero makes every index share the base address. In that mode the 16-bit write data names the index.

Only a 2-byte write that lands exactly on an index's address, with an index below `N_NOTIFY`, fires a pulse. Any other write fires no pulse and raises `wr_error` in the cycle the pulse would have appeared. The configuration is checked continuously against the layout rules. A broken configuration shows on `cfg_error` and stops all decoding. The multiplier is restricted to powers of four, so the index comes from a right shift by the multiplier's bit position and no divider is needed.

Top module: `aux_ntf_doorbell`

## Requirements
- R1: During and right after a synchronous reset, `notify_pulse` is all zeros and `wr_error` is low.
- R2: With a valid non-zero multiplier, a write with `wr_size` = 1 (2 bytes) at `cfg_base + k*cfg_mult`, where k < N_NOTIFY, sets bit k of `notify_pulse`. The bit is set in the cycle after the write is sampled and is high for that one cycle only, with `wr_error` low.
- R3: With `cfg_mult` = 0, a 2-byte write at exactly `cfg_base` whose data is below N_NOTIFY sets the `notify_pulse` bit numbered by the data, one cycle later.
- R4: With `cfg_mult` = 0, a write whose data is N_NOTIFY or more, or whose address differs from `cfg_base`, gives `wr_error` one cycle later and no pulse.
- R5: A write with any `wr_size` other than 1 gives `wr_error` and no pulse. The encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R6: With a non-zero multiplier, a write below `cfg_base`, or at an offset from it that is not a multiple of `cfg_mult`, gives `wr_error` and no pulse.
- R7: With a non-zero multiplier, an aligned write whose index `(addr - base) / mult` is N_NOTIFY or more gives `wr_error` and no pulse.
- R8: `cfg_error` goes high, combinationally, whenever bit 0 of `cfg_base` is set.
- R9: `cfg_error` goes high whenever `cfg_mult` is non-zero and is not 4 to the power n (1, 4, 16, ...).
- R10: `cfg_error` goes high whenever `cfg_len` is below 2 or below `(N_NOTIFY-1)*cfg_mult + 2`. The check uses full-width arithmetic, and equality is accepted.
- R11: A write sampled while `cfg_error` is high gives `wr_error` and no pulse, including when the configuration changes in the same cycle as the write.
- R12: A cycle with no write gives no pulse and no error in the next cycle. At most one pulse bit is set at a time, and a pulse never coincides with `wr_error`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Window offset of index 0 |
| cfg_mult | input | ADDR_W | Address stride between indices (0 = shared address) |
| cfg_len | input | ADDR_W | Window length in bytes |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_addr | input | ADDR_W | Write byte offset inside the window |
| wr_size | input | 2 | Write size code (0=1B, 1=2B, 2=4B, 3=8B) |
| wr_data | input | DATA_W | Write data (index source in shared mode) |
| notify_pulse | output | N_NOTIFY | One-cycle pulse per notification index |
| wr_error | output | 1 | One-cycle flag for a rejected write |
| cfg_error | output | 1 | Configuration breaks the layout rules |

## Verification
Two functions can fall in the same cycle: a configuration change and a doorbell write. The configuration check is combinational while the write result is registered, so the verdict for a write must use the configuration present at the edge where the write is sampled. The bench provokes this by driving an odd base and a valid write on the same clock. It expects `wr_error` and an empty pulse vector one cycle later. It also switches between legal and illegal random configurations in the middle of a stream of random writes, and the bench model predicts each outcome from the configuration driven with that write.

// File: rtl/aux_ntf_pkg.sv
package aux_ntf_pkg;

    // Write size code: log2 of the byte count
    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } wr_size_e;

    // Why a write was accepted or refused
    typedef enum logic [2:0] {
        VD_HIT        = 3'd0,
        VD_CFG_BLOCK  = 3'd1,
        VD_BAD_SIZE   = 3'd2,
        VD_BELOW_BASE = 3'd3,
        VD_MISALIGNED = 3'd4,
        VD_NO_INDEX   = 3'd5,
        VD_ADDR_MISS  = 3'd6
    } verdict_e;

    typedef struct packed {
        logic     fire;
        logic     reject;
        verdict_e why;
    } decode_s;

    // Position of the highest set bit (0 when the input is zero)
    function automatic logic [5:0] top_bit_pos(input logic [31:0] v);
        logic [5:0] p;
        p = '0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) p = 6'(i);
        end
        return p;
    endfunction

    // True when exactly one bit is set
    function automatic logic single_bit(input logic [31:0] v);
        return (v != '0) && ((v & (v - 32'd1)) == '0);
    endfunction

endpackage

// File: rtl/aux_ntf_cfg_check.sv
module aux_ntf_cfg_check
    import aux_ntf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int N_NOTIFY = 8,
    parameter int SH_W     = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mult,
    input  logic [ADDR_W-1:0] cfg_len,
    output logic              cfg_ok,
    output logic              mult_zero,
    output logic [SH_W-1:0]   shamt
);
    localparam int SPAN_W = ADDR_W + $clog2(N_NOTIFY + 1) + 2;

    logic              base_bad;
    logic              mult_bad;
    logic              len_bad;
    logic [5:0]        mpos;
    logic [SPAN_W-1:0] span_need;

    always_comb begin
        base_bad  = cfg_base[0];
        mult_zero = (cfg_mult == '0);
        mpos      = top_bit_pos(32'(cfg_mult));
        mult_bad  = !mult_zero && (!single_bit(32'(cfg_mult)) || mpos[0]);
        span_need = SPAN_W'(N_NOTIFY - 1) * SPAN_W'(cfg_mult) + SPAN_W'(2);
        len_bad   = (cfg_len < ADDR_W'(2)) || (SPAN_W'(cfg_len) < span_need);
        cfg_ok    = !base_bad && !mult_bad && !len_bad;
        shamt     = mpos[SH_W-1:0];
    end

endmodule

// File: rtl/aux_ntf_index_calc.sv
module aux_ntf_index_calc
    import aux_ntf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int N_NOTIFY = 8,
    parameter int SH_W     = $clog2(ADDR_W),
    parameter int IDX_W    = (N_NOTIFY > 1) ? $clog2(N_NOTIFY) : 1
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  wr_size_e          wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mult,
    input  logic              cfg_ok,
    input  logic              mult_zero,
    input  logic [SH_W-1:0]   shamt,
    output decode_s           dec,
    output logic [IDX_W-1:0]  idx
);
    localparam int CMP_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] low_mask;
    logic [CMP_W-1:0]  idx_from_addr;
    logic [CMP_W-1:0]  idx_from_data;
    logic [CMP_W-1:0]  idx_sel;
    logic              below;
    logic              misaligned;
    logic              in_range;
    verdict_e          why;

    always_comb begin
        offset        = wr_addr - cfg_base;
        low_mask      = cfg_mult - ADDR_W'(1);
        below         = wr_addr < cfg_base;
        misaligned    = |(offset & low_mask);
        idx_from_addr = CMP_W'(offset >> shamt);
        idx_from_data = CMP_W'(wr_data);
        idx_sel       = mult_zero ? idx_from_data : idx_from_addr;
        in_range      = idx_sel < CMP_W'(N_NOTIFY);

        if (!cfg_ok)                  why = VD_CFG_BLOCK;
        else if (wr_size != SZ_2B)    why = VD_BAD_SIZE;
        else if (mult_zero) begin
            if (wr_addr != cfg_base)  why = VD_ADDR_MISS;
            else if (!in_range)       why = VD_NO_INDEX;
            else                      why = VD_HIT;
        end
        else if (below)               why = VD_BELOW_BASE;
        else if (misaligned)          why = VD_MISALIGNED;
        else if (!in_range)           why = VD_NO_INDEX;
        else                          why = VD_HIT;

        dec.why    = why;
        dec.fire   = wr_valid && (why == VD_HIT);
        dec.reject = wr_valid && (why != VD_HIT);
        idx        = idx_sel[IDX_W-1:0];
    end

endmodule

// File: rtl/aux_ntf_pulse_gen.sv
module aux_ntf_pulse_gen
    import aux_ntf_pkg::*;
#(
    parameter int N_NOTIFY = 8,
    parameter int IDX_W    = (N_NOTIFY > 1) ? $clog2(N_NOTIFY) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  decode_s             dec,
    input  logic [IDX_W-1:0]    idx,
    output logic [N_NOTIFY-1:0] pulse_q,
    output logic                err_q
);
    for (genvar g = 0; g < N_NOTIFY; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) pulse_q[g] <= 1'b0;
            else     pulse_q[g] <= dec.fire && (idx == IDX_W'(g));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= dec.reject;
    end

    AST_FIRE_REJECT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dec.fire && dec.reject)); // R12

endmodule

// File: rtl/aux_ntf_doorbell.sv
module aux_ntf_doorbell
    import aux_ntf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int N_NOTIFY = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [ADDR_W-1:0]   cfg_mult,
    input  logic [ADDR_W-1:0]   cfg_len,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [1:0]          wr_size,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [N_NOTIFY-1:0] notify_pulse,
    output logic                wr_error,
    output logic                cfg_error
);
    localparam int SH_W  = $clog2(ADDR_W);
    localparam int IDX_W = (N_NOTIFY > 1) ? $clog2(N_NOTIFY) : 1;

    logic             cfg_ok;
    logic             mult_zero;
    logic [SH_W-1:0]  shamt;
    decode_s          dec;
    logic [IDX_W-1:0] idx;
    wr_size_e         size_e;

    assign size_e    = wr_size_e'(wr_size);
    assign cfg_error = !cfg_ok;

    aux_ntf_cfg_check #(
        .ADDR_W   (ADDR_W),
        .N_NOTIFY (N_NOTIFY),
        .SH_W     (SH_W)
    ) u_cfg (
        .cfg_base  (cfg_base),
        .cfg_mult  (cfg_mult),
        .cfg_len   (cfg_len),
        .cfg_ok    (cfg_ok),
        .mult_zero (mult_zero),
        .shamt     (shamt)
    );

    aux_ntf_index_calc #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .N_NOTIFY (N_NOTIFY),
        .SH_W     (SH_W),
        .IDX_W    (IDX_W)
    ) u_idx (
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_size   (size_e),
        .wr_data   (wr_data),
        .cfg_base  (cfg_base),
        .cfg_mult  (cfg_mult),
        .cfg_ok    (cfg_ok),
        .mult_zero (mult_zero),
        .shamt     (shamt),
        .dec       (dec),
        .idx       (idx)
    );

    aux_ntf_pulse_gen #(
        .N_NOTIFY (N_NOTIFY),
        .IDX_W    (IDX_W)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .idx     (idx),
        .pulse_q (notify_pulse),
        .err_q   (wr_error)
    );

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(notify_pulse)); // R12
    AST_PULSE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((|notify_pulse) && wr_error)); // R12
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (notify_pulse == '0) && !wr_error); // R12
    AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && cfg_error) |=> (notify_pulse == '0) && wr_error); // R11
    AST_SIZE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_size != 2'd1) |=> (notify_pulse == '0) && wr_error); // R5
    AST_ODD_BASE_CFG: assert property (@(posedge clk) disable iff (rst)
        cfg_base[0] |-> cfg_error); // R8

endmodule

// File: tb/aux_ntf_doorbell_bench.sv
module aux_ntf_doorbell_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int N      = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] cfg_base, cfg_mult, cfg_len;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [1:0]        wr_size;
    logic [DATA_W-1:0] wr_data;
    logic [N-1:0]      notify_pulse;
    logic              wr_error;
    logic              cfg_error;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    aux_ntf_doorbell #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_NOTIFY(N)) u_aux_ntf_doorbell (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_mult(cfg_mult), .cfg_len(cfg_len),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .notify_pulse(notify_pulse), .wr_error(wr_error), .cfg_error(cfg_error)
    );

    function automatic bit model_cfg_ok(int b, int m, int l);
        bit mok = (m == 0);
        for (int k = 0; k < ADDR_W; k += 2) if (m == (1 << k)) mok = 1;
        return (b % 2 == 0) && mok && (l >= 2) && (l >= (N - 1) * m + 2);
    endfunction

    function automatic void model_wr(input int b, m, l, a, sz, d,
                                     output logic [N-1:0] p, output bit e, output string tag);
        int off;
        p = '0; e = 1;
        if (!model_cfg_ok(b, m, l)) begin tag = "R11"; return; end
        if (sz != 1) begin tag = "R5"; return; end
        if (m == 0) begin
            if (a == b && d < N) begin p[d] = 1'b1; e = 0; tag = "R3"; end
            else tag = "R4";
            return;
        end
        if (a < b || ((a - b) % m) != 0) begin tag = "R6"; return; end
        off = (a - b) / m;
        if (off >= N) begin tag = "R7"; return; end
        p[off] = 1'b1; e = 0; tag = "R2";
    endfunction

    task automatic check(string tag, logic [N-1:0] ap, logic ae, logic [N-1:0] xp, logic xe);
        total++;
        if (ap !== xp || ae !== xe) begin
            bad++;
            $display("FAIL %s: pulse=%b err=%b expected pulse=%b err=%b", tag, ap, ae, xp, xe);
        end
    endtask

    task automatic check_cfg(string tag);
        total++;
        if (cfg_error !== !model_cfg_ok(int'(cfg_base), int'(cfg_mult), int'(cfg_len))) begin
            bad++;
            $display("FAIL %s: cfg_error=%b expected %b", tag, cfg_error,
                     !model_cfg_ok(int'(cfg_base), int'(cfg_mult), int'(cfg_len)));
        end
    endtask

    task automatic set_cfg(int b, int m, int l, string tag);
        @(negedge clk);
        cfg_base = ADDR_W'(b); cfg_mult = ADDR_W'(m); cfg_len = ADDR_W'(l);
        #1 check_cfg(tag);
    endtask

    // Drive one write (optionally with a new config in the same cycle), check one cycle later
    task automatic do_wr(int a, int sz, int d, bit new_cfg = 0, int nb = 0, int nm = 0, int nl = 0);
        logic [N-1:0] xp; bit xe; string tag;
        @(negedge clk);
        if (new_cfg) begin
            cfg_base = ADDR_W'(nb); cfg_mult = ADDR_W'(nm); cfg_len = ADDR_W'(nl);
        end
        wr_valid = 1; wr_addr = ADDR_W'(a); wr_size = 2'(sz); wr_data = DATA_W'(d);
        model_wr(int'(cfg_base), int'(cfg_mult), int'(cfg_len), int'(wr_addr), sz,
                 int'(wr_data), xp, xe, tag);
        @(negedge clk);
        wr_valid = 0;
        check(tag, notify_pulse, wr_error, xp, xe);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R12 idle", notify_pulse, wr_error, '0, 1'b0);
    endtask

    initial begin
        int seed, b, m, l, k, a, sz, d;
        int mults [6] = '{0, 1, 4, 16, 64, 256};
        seed = $urandom(32'h5EED1234);
        rst = 1; wr_valid = 0; wr_addr = '0; wr_size = 2'd1; wr_data = '0;
        cfg_base = 16'h40; cfg_mult = 16'd4; cfg_len = 16'd30;
        repeat (3) @(negedge clk);
        check("R1 in reset", notify_pulse, wr_error, '0, 1'b0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", notify_pulse, wr_error, '0, 1'b0);

        // Configuration rules
        set_cfg(16'h41, 4, 100, "R8 odd base");
        set_cfg(16'h40, 2, 100, "R9 mult 2");
        set_cfg(16'h40, 8, 100, "R9 mult 8");
        set_cfg(16'h40, 3, 100, "R9 mult 3");
        set_cfg(16'h80, 0, 1, "R10 len 1");
        set_cfg(16'h40, 4, (N - 1) * 4 + 1, "R10 len short");
        set_cfg(16'h40, 16384, 16'hFFFF, "R10 overflow span");
        set_cfg(16'h40, 4, (N - 1) * 4 + 2, "R10 len exact");

        // Strided mode, every index
        for (int i = 0; i < N; i++) do_wr(16'h40 + i * 4, 1, 0);
        idle_check();
        do_wr(16'h40 + N * 4, 1, 0);      // R7
        do_wr(16'h3C, 1, 0);              // R6 below base
        do_wr(16'h42, 1, 0);              // R6 misaligned
        do_wr(16'h44, 0, 0);              // R5 one byte
        do_wr(16'h44, 2, 0);              // R5 four bytes
        idle_check();

        // Shared-address mode
        set_cfg(16'h80, 0, 2, "R10 shared len 2");
        for (int i = 0; i < N; i++) do_wr(16'h80, 1, i);
        do_wr(16'h80, 1, N);              // R4 data too big
        do_wr(16'h82, 1, 1);              // R4 address miss
        do_wr(16'h80, 3, 1);              // R5

        // Config goes bad in the same cycle as a write
        do_wr(16'h80, 1, 2, 1, 16'h81, 0, 2);   // R11
        do_wr(16'h80, 1, 2, 1, 16'h80, 0, 2);   // R3 back to legal

        // Random mix
        for (int it = 0; it < 3000; it++) begin
            if (it % 200 == 0) begin
                m = mults[$urandom_range(0, 5)];
                b = 2 * $urandom_range(0, 512);
                l = (N - 1) * m + 2 + $urandom_range(0, 6);
                case ($urandom_range(0, 7))
                    0: b = b + 1;
                    1: m = m * 2 + ((m == 0) ? 2 : 0);
                    2: l = l - $urandom_range(1, 2);
                    default: ;
                endcase
                set_cfg(b, m, l, "R8/R9/R10 random cfg");
            end
            k = $urandom_range(0, N + 1);
            a = int'(cfg_base) + k * int'(cfg_mult);
            case ($urandom_range(0, 9))
                0: a = a + 2;
                1: a = a - 2;
                2: a = int'(cfg_base) - 4;
                default: ;
            endcase
            a = a & 16'hFFFF;
            sz = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 3)) : 1;
            d = $urandom_range(0, N + 3);
            do_wr(a, sz, d);
            if ($urandom_range(0, 15) == 0) idle_check();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule